// File: doc/BRIEF.md
# Aligned Region Window Allocator

This block turns address regions into translation windows. Each region arrives as a command carrying a physical start, a bus start, a size and a 32-bit action code. The block cuts the region into pieces whose sizes are powers of two, each aligned to its own physical start. It then writes each piece into a bank of window registers through a valid/ready register write port. One write goes out per accepted transfer.

Successive regions within one allocation session fill consecutive windows. If a region cannot be fully covered, the session enters an error state, and all further regions in that session are accepted but ignored. A close command ends the session. On close, the block zeroes every window it did not fill, or every window if the session failed. It then pulses `done` and presents the session's error status.

Each window takes seven 32-bit registers, and the register index selects one of them:

| Index | Content |
|---|---|
| 0 | Match low word, with bit 0 set as the window enable |
| 1 | Match high word |
| 2 | Translated (bus) start, low word |
| 3 | Translated (bus) start, high word |
| 4 | Mask, low word |
| 5 | Mask, high word |
| 6 | Action code |

The write address is `{window, index}`, with the index in bits [2:0].

Top module: `window_alloc`

## Requirements
- R1: Each piece size is the smaller of (a) the largest power of two not above the remaining size and (b) the lowest set bit of the current physical start. A physical start of zero places no alignment limit on the piece.
- R2: Each piece is written as seven transfers, register indices 0 to 6 in ascending order, at write address `{window, index}`. Index 0 carries the low match word with bit 0 set to 1. Index 1 carries the high match word. Index 6 carries the action code.
- R3: The mask, carried in indices 4 (low word) and 5 (high word), equals the bitwise inverse of (piece size - 1) with bits [15:0] forced to zero.
- R4: After each piece, the physical start and the bus start both advance by the piece size. The bus start is carried in indices 2 (low word) and 3 (high word). The window number keeps counting up across the regions of one session.
- R5: If the next piece would be smaller than 64 KiB (0x10000), allocation of the region stops, nothing is written for that piece, and the session error is set.
- R6: If a region still has size left once all NUM_WIN windows are used, the session error is set.
- R7: While the session error is set, region commands are accepted and produce no writes.
- R8: On close, every window from the next free one up to NUM_WIN-1 receives seven writes of zero. After an error, this starts at window 0 instead. If all windows are in use and there is no error, no clear writes are made.
- R9: After the last clear write, or at once if none are needed, `done` is high for exactly one cycle. At the same time `err` takes the session's error value and holds it until the next `done`. The next session then starts at window 0 with no error.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady.
- R11: After reset, `wr_valid`, `done` and `err` are low and `cmd_ready` is high.
- R12: A region of size zero produces no writes and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_close | input | 1 | 1: close the session; 0: the command carries a region |
| cmd_phys | input | ADDR_W | Region physical start |
| cmd_bus | input | ADDR_W | Region bus start |
| cmd_size | input | ADDR_W | Region size in bytes |
| cmd_action | input | 32 | Action code stored in each window |
| wr_valid | output | 1 | Register write pending |
| wr_ready | input | 1 | Window bank accepts the write |
| wr_addr | output | WA_W | {window, register index} |
| wr_data | output | 32 | Register write data |
| done | output | 1 | One-cycle pulse at the end of a session |
| err | output | 1 | Error status of the last finished session |

## Verification
The hardest case to reach is the exact-fill boundary. The windows must be consumed with no size left over, so the close then needs no clear writes at all. One more region must also arrive with windows exhausted. The stimulus reaches this with a region at a 64 KiB-aligned start above 4 GiB whose size is the sum of eight doubling pieces. That region takes exactly eight windows. One session closes right after it, and another session sends one further 64 KiB region first. Separate sessions cover three more cases: a start of zero, a tail smaller than 64 KiB, and a start misaligned below 64 KiB. In all of them the write port's ready line is toggled in a pseudo-random pattern.

// File: rtl/wa_pkg.sv
package wa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CALC  = 2'd1,
    ST_WRITE = 2'd2,
    ST_CLEAR = 2'd3
  } wa_state_t;

  localparam logic [2:0] REG_MATCH_LO = 3'd0;
  localparam logic [2:0] REG_MATCH_HI = 3'd1;
  localparam logic [2:0] REG_REMAP_LO = 3'd2;
  localparam logic [2:0] REG_REMAP_HI = 3'd3;
  localparam logic [2:0] REG_MASK_LO  = 3'd4;
  localparam logic [2:0] REG_MASK_HI  = 3'd5;
  localparam logic [2:0] REG_ACTION   = 3'd6;
  localparam logic [2:0] REG_LAST     = 3'd6;
endpackage

// File: rtl/wa_chunk.sv
module wa_chunk #(
  parameter int ADDR_W    = 64,
  parameter int MIN_SHIFT = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] remain,
  output logic [ADDR_W-1:0] chunk,
  output logic              too_small
);
  localparam logic [ADDR_W-1:0] MIN_CHUNK = ADDR_W'(1) << MIN_SHIFT;

  logic [ADDR_W-1:0] top_pow;
  logic [ADDR_W-1:0] align;

  always_comb begin
    top_pow = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (remain[i]) top_pow = ADDR_W'(1) << i;
    end
    align = base & (~base + ADDR_W'(1));
    if (base == '0 || top_pow < align) chunk = top_pow;
    else                               chunk = align;
    too_small = (chunk < MIN_CHUNK);
  end
endmodule

// File: rtl/wa_fmt.sv
module wa_fmt #(
  parameter int ADDR_W = 64
) (
  input  logic [2:0]        sel,
  input  logic [ADDR_W-1:0] phys,
  input  logic [ADDR_W-1:0] bus,
  input  logic [ADDR_W-1:0] mask,
  input  logic [31:0]       action,
  output logic [31:0]       data
);
  import wa_pkg::*;

  logic [63:0] phys_x, bus_x, mask_x;

  always_comb begin
    phys_x = 64'(phys);
    bus_x  = 64'(bus);
    mask_x = 64'(mask);
    case (sel)
      REG_MATCH_LO: data = phys_x[31:0] | 32'd1;
      REG_MATCH_HI: data = phys_x[63:32];
      REG_REMAP_LO: data = bus_x[31:0];
      REG_REMAP_HI: data = bus_x[63:32];
      REG_MASK_LO:  data = mask_x[31:0];
      REG_MASK_HI:  data = mask_x[63:32];
      REG_ACTION:   data = action;
      default:      data = '0;
    endcase
  end
endmodule

// File: rtl/wa_ctrl.sv
module wa_ctrl #(
  parameter int ADDR_W    = 64,
  parameter int NUM_WIN   = 8,
  parameter int MIN_SHIFT = 16,
  localparam int WIN_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int IDX_W = $clog2(NUM_WIN + 1),
  localparam int WA_W  = WIN_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_close,
  input  logic [ADDR_W-1:0] cmd_phys,
  input  logic [ADDR_W-1:0] cmd_bus,
  input  logic [ADDR_W-1:0] cmd_size,
  input  logic [31:0]       cmd_action,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [WA_W-1:0]   wr_addr,
  output logic [31:0]       wr_data,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] cur_phys,
  output logic [ADDR_W-1:0] cur_bus,
  output logic [ADDR_W-1:0] cur_size,
  output logic [ADDR_W-1:0] cur_mask,
  output logic [31:0]       cur_action,
  output logic [2:0]        fmt_sel,
  input  logic [31:0]       fmt_data,
  input  logic [ADDR_W-1:0] chunk,
  input  logic              too_small
);
  import wa_pkg::*;

  localparam logic [ADDR_W-1:0] LOW_KEEP = ~((ADDR_W'(1) << MIN_SHIFT) - ADDR_W'(1));
  localparam logic [IDX_W-1:0]  FULL     = IDX_W'(NUM_WIN);
  localparam logic [IDX_W-1:0]  LAST_WIN = IDX_W'(NUM_WIN - 1);

  wa_state_t         st_q;
  logic [ADDR_W-1:0] phys_q, bus_q, size_q, chunk_q, mask_q;
  logic [31:0]       act_q;
  logic [IDX_W-1:0]  idx_q, clr_q;
  logic [2:0]        reg_q;
  logic              err_q;
  logic              wv_q, done_q, err_o_q;
  logic [WA_W-1:0]   wa_q;
  logic [31:0]       wd_q;
  logic              accept;
  logic [IDX_W-1:0]  clr_start;

  assign accept     = wv_q && wr_ready;
  assign clr_start  = err_q ? '0 : idx_q;
  assign cmd_ready  = (st_q == ST_IDLE);
  assign fmt_sel    = (st_q == ST_WRITE) ? (reg_q + 3'd1) : REG_MATCH_LO;
  assign cur_phys   = phys_q;
  assign cur_bus    = bus_q;
  assign cur_size   = size_q;
  assign cur_mask   = mask_q;
  assign cur_action = act_q;
  assign wr_valid   = wv_q;
  assign wr_addr    = wa_q;
  assign wr_data    = wd_q;
  assign done       = done_q;
  assign err        = err_o_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      phys_q  <= '0;
      bus_q   <= '0;
      size_q  <= '0;
      chunk_q <= '0;
      mask_q  <= '0;
      act_q   <= '0;
      idx_q   <= '0;
      clr_q   <= '0;
      reg_q   <= '0;
      err_q   <= 1'b0;
      wv_q    <= 1'b0;
      wa_q    <= '0;
      wd_q    <= '0;
      done_q  <= 1'b0;
      err_o_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            if (cmd_close) begin
              if (clr_start == FULL) begin
                done_q  <= 1'b1;
                err_o_q <= err_q;
                err_q   <= 1'b0;
                idx_q   <= '0;
              end else begin
                clr_q <= clr_start;
                reg_q <= '0;
                wv_q  <= 1'b1;
                wa_q  <= {clr_start[WIN_W-1:0], REG_MATCH_LO};
                wd_q  <= '0;
                st_q  <= ST_CLEAR;
              end
            end else if (!err_q) begin
              phys_q <= cmd_phys;
              bus_q  <= cmd_bus;
              size_q <= cmd_size;
              act_q  <= cmd_action;
              st_q   <= ST_CALC;
            end
          end
        end
        ST_CALC: begin
          if (size_q == '0) begin
            st_q <= ST_IDLE;
          end else if (idx_q == FULL || too_small) begin
            err_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else begin
            chunk_q <= chunk;
            mask_q  <= ~(chunk - ADDR_W'(1)) & LOW_KEEP;
            reg_q   <= REG_MATCH_LO;
            wv_q    <= 1'b1;
            wa_q    <= {idx_q[WIN_W-1:0], REG_MATCH_LO};
            wd_q    <= fmt_data;
            st_q    <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (accept) begin
            if (reg_q == REG_LAST) begin
              wv_q   <= 1'b0;
              phys_q <= phys_q + chunk_q;
              bus_q  <= bus_q + chunk_q;
              size_q <= size_q - chunk_q;
              idx_q  <= idx_q + IDX_W'(1);
              st_q   <= ST_CALC;
            end else begin
              reg_q <= reg_q + 3'd1;
              wa_q  <= {idx_q[WIN_W-1:0], reg_q + 3'd1};
              wd_q  <= fmt_data;
            end
          end
        end
        ST_CLEAR: begin
          if (accept) begin
            if (reg_q == REG_LAST) begin
              if (clr_q == LAST_WIN) begin
                wv_q    <= 1'b0;
                done_q  <= 1'b1;
                err_o_q <= err_q;
                err_q   <= 1'b0;
                idx_q   <= '0;
                st_q    <= ST_IDLE;
              end else begin
                clr_q <= clr_q + IDX_W'(1);
                reg_q <= '0;
                wa_q  <= {clr_q[WIN_W-1:0] + WIN_W'(1), REG_MATCH_LO};
              end
            end else begin
              reg_q <= reg_q + 3'd1;
              wa_q  <= {clr_q[WIN_W-1:0], reg_q + 3'd1};
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/window_alloc.sv
module window_alloc #(
  parameter int ADDR_W    = 64,
  parameter int NUM_WIN   = 8,
  parameter int MIN_SHIFT = 16,
  localparam int WIN_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int WA_W  = WIN_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_close,
  input  logic [ADDR_W-1:0] cmd_phys,
  input  logic [ADDR_W-1:0] cmd_bus,
  input  logic [ADDR_W-1:0] cmd_size,
  input  logic [31:0]       cmd_action,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [WA_W-1:0]   wr_addr,
  output logic [31:0]       wr_data,
  output logic              done,
  output logic              err
);
  logic [ADDR_W-1:0] cur_phys, cur_bus, cur_size, cur_mask, chunk;
  logic [31:0]       cur_action, fmt_data;
  logic [2:0]        fmt_sel;
  logic              too_small;

  wa_chunk #(.ADDR_W(ADDR_W), .MIN_SHIFT(MIN_SHIFT)) u_chunk (
    .base(cur_phys), .remain(cur_size), .chunk(chunk), .too_small(too_small)
  );

  wa_fmt #(.ADDR_W(ADDR_W)) u_fmt (
    .sel(fmt_sel), .phys(cur_phys), .bus(cur_bus), .mask(cur_mask),
    .action(cur_action), .data(fmt_data)
  );

  wa_ctrl #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .MIN_SHIFT(MIN_SHIFT)) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_close(cmd_close),
    .cmd_phys(cmd_phys), .cmd_bus(cmd_bus), .cmd_size(cmd_size),
    .cmd_action(cmd_action),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done), .err(err),
    .cur_phys(cur_phys), .cur_bus(cur_bus), .cur_size(cur_size),
    .cur_mask(cur_mask), .cur_action(cur_action),
    .fmt_sel(fmt_sel), .fmt_data(fmt_data),
    .chunk(chunk), .too_small(too_small)
  );
endmodule

// File: rtl/wa_checker.sv
module wa_checker #(
  parameter int WA_W = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_ready,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic [WA_W-1:0] wr_addr,
  input logic [31:0]     wr_data,
  input logic            done
);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_valid);

  p_mask_low_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr[2:0] == 3'd4) |-> (wr_data[15:0] == 16'h0));

  p_match_align_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr[2:0] == 3'd0) |-> (wr_data[15:1] == 15'h0));

  p_index_range_r2: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_addr[2:0] != 3'd7));

  p_busy_r11: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> !cmd_ready);
endmodule

bind window_alloc wa_checker #(.WA_W(WA_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
);

// File: tb/sim_window_alloc.sv
module sim_window_alloc;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_close = 1'b0;
  logic        cmd_ready;
  logic [63:0] cmd_phys = '0, cmd_bus = '0, cmd_size = '0;
  logic [31:0] cmd_action = '0;
  logic        wr_valid, wr_ready = 1'b0;
  logic [5:0]  wr_addr;
  logic [31:0] wr_data;
  logic        done, err;

  int tests = 0, fails = 0;

  logic [5:0]  q_addr[$];
  logic [31:0] q_data[$];
  string       q_req[$];
  logic        q_err[$];
  string       q_err_req[$];

  int   m_idx = 0;
  logic m_err = 1'b0;
  logic [7:0] lfsr = 8'h5a;
  logic rand_ready = 1'b1;

  window_alloc u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_close(cmd_close), .cmd_phys(cmd_phys), .cmd_bus(cmd_bus),
    .cmd_size(cmd_size), .cmd_action(cmd_action), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] m_piece(input logic [63:0] p, input logic [63:0] s);
    logic [63:0] hp, al;
    hp = 0;
    al = 0;
    for (int i = 63; i >= 0; i--) if (hp == 0 && s[i]) hp = 64'd1 << i;
    if (p == 0) return hp;
    for (int i = 0; i < 64; i++) if (al == 0 && p[i]) al = 64'd1 << i;
    return (al < hp) ? al : hp;
  endfunction

  task automatic push(input int w, input int r, input logic [31:0] d, input string req);
    q_addr.push_back({w[2:0], r[2:0]});
    q_data.push_back(d);
    q_req.push_back(req);
  endtask

  task automatic model_region(input logic [63:0] p, input logic [63:0] b,
                              input logic [63:0] s, input logic [31:0] a);
    logic [63:0] c, mk;
    if (m_err) return;
    while (m_idx < NW && s != 0) begin
      c = m_piece(p, s);
      if (c < 64'h10000) break;
      mk = ~(c - 1) & ~64'hffff;
      push(m_idx, 0, p[31:0] | 32'd1, "R1 match-low");
      push(m_idx, 1, p[63:32], "R1 match-high");
      push(m_idx, 2, b[31:0], "R4 remap-low");
      push(m_idx, 3, b[63:32], "R4 remap-high");
      push(m_idx, 4, mk[31:0], "R3 mask-low");
      push(m_idx, 5, mk[63:32], "R3 mask-high");
      push(m_idx, 6, a, "R2 action");
      p += c;
      b += c;
      s -= c;
      m_idx++;
    end
    if (s != 0) m_err = 1'b1;
  endtask

  task automatic send(input logic close, input logic [63:0] p, input logic [63:0] b,
                      input logic [63:0] s, input logic [31:0] a);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_close = close;
    cmd_phys = p; cmd_bus = b; cmd_size = s; cmd_action = a;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #1;
    cmd_valid = 1'b0; cmd_close = 1'b0;
  endtask

  task automatic region(input logic [63:0] p, input logic [63:0] b,
                        input logic [63:0] s, input logic [31:0] a);
    model_region(p, b, s, a);
    send(1'b0, p, b, s, a);
  endtask

  task automatic close_session(input string req);
    int start;
    start = m_err ? 0 : m_idx;
    for (int w = start; w < NW; w++)
      for (int r = 0; r < 7; r++) push(w, r, 32'd0, "R8 clear");
    q_err.push_back(m_err);
    q_err_req.push_back(req);
    m_err = 1'b0;
    m_idx = 0;
    send(1'b1, 0, 0, 0, 0);
    @(negedge clk);
    while (q_err.size() != 0) @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wr_ready <= rand_ready ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  logic        hold_pend = 1'b0;
  logic [37:0] hold_val;
  logic        prev_done = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (hold_pend)
        check(wr_valid && {wr_addr, wr_data} == hold_val, "R10 hold", {wr_valid, wr_addr, wr_data}, {1'b1, hold_val});
      hold_pend <= wr_valid && !wr_ready;
      hold_val  <= {wr_addr, wr_data};
      if (wr_valid && wr_ready) begin
        if (q_addr.size() == 0) begin
          check(1'b0, "R7 R8 unexpected write", {wr_addr, wr_data}, 0);
        end else begin
          check(wr_addr == q_addr[0] && wr_data == q_data[0], q_req[0],
                {wr_addr, wr_data}, {q_addr[0], q_data[0]});
          void'(q_addr.pop_front());
          void'(q_data.pop_front());
          void'(q_req.pop_front());
        end
      end
      if (done) begin
        check(!prev_done, "R9 single-cycle done", 1, 0);
        check(q_addr.size() == 0, "R8 writes outstanding at done", q_addr.size(), 0);
        if (q_err.size() == 0) begin
          check(1'b0, "R9 unexpected done", 1, 0);
        end else begin
          check(err == q_err[0], q_err_req[0], err, q_err[0]);
          void'(q_err.pop_front());
          void'(q_err_req.pop_front());
        end
      end
      prev_done <= done;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!wr_valid, "R11 wr_valid", wr_valid, 0);
    check(!done, "R11 done", done, 0);
    check(!err, "R11 err", err, 0);
    check(cmd_ready, "R11 cmd_ready", cmd_ready, 1);

    // Session A: alignment-limited pieces (R1, R4), clears after 3 windows (R8)
    rand_ready = 1'b0;
    region(64'hE800_0000, 64'h0, 64'h0100_0000, 32'h4);
    region(64'hE900_0000, 64'h1000_0000, 64'h0300_0000, 32'h0);
    close_session("R9 err after good session");
    check(!err, "R9 err held low", err, 0);

    // Session B: zero start (R1), tail below 64 KiB (R5), skip after error (R7)
    rand_ready = 1'b1;
    region(64'h0, 64'h8000_0000, 64'h30000, 32'h11);
    region(64'h0, 64'h0, 64'h0, 32'h0);                  // R12 zero size
    region(64'h0010_0000, 64'h0020_0000, 64'h18000, 32'h22); // R5
    region(64'h0040_0000, 64'h0, 64'h0001_0000, 32'h33);   // R7 skipped
    close_session("R5 R7 err after short tail");
    repeat (3) @(negedge clk);
    check(err, "R9 err held high", err, 1);

    // Session C: exactly NUM_WIN windows above 4 GiB, close needs no clears (R8)
    region(64'h1_0001_0000, 64'h2_0000_0000, 64'hFF_0000, 32'h55);
    close_session("R6 exact fill no error");

    // Session D: exact fill then one more region overflows (R6)
    region(64'h1_0001_0000, 64'h3_0000_0000, 64'hFF_0000, 32'h66);
    region(64'h5000_0000, 64'h0, 64'h1_0000, 32'h77);
    close_session("R6 window overflow");

    // Session E: misaligned start below 64 KiB (R5), then zero-size only session (R12)
    region(64'h0000_8000, 64'h0, 64'h20000, 32'h88);
    close_session("R5 misaligned start");
    region(64'h0, 64'h0, 64'h0, 32'h99);
    close_session("R12 zero size no error");

    repeat (5) @(negedge clk);
    check(q_addr.size() == 0, "R8 queue drained", q_addr.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule